// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Minute Alarm

This block keeps a 24-hour time of day and a calendar date in BCD registers. Software reaches these registers over a simple byte-wide register bus with an 8-bit address, 8-bit write data, a write strobe and a combinational read port. A prescaler divides the `tick_in` enable pulses by `TICKS_PER_SEC` to produce one second. Each second a carry state machine steps through the fields in turn: seconds, minutes, hours, day (with weekday), month and year. The chain stops at the first field that does not wrap.

Whenever the seconds roll over to 00, the block compares minute, hour and date against three alarm registers. Three flags record events: a match sets the alarm flag, every minute rollover sets the periodic-update flag, and a stub input sets the timer flag. Two further flags, power-on and low-voltage, mark the time as untrustworthy. All flags are sticky and are cleared only by writing a 0 to their bit.

`irq_n` is active low. It is asserted while any event flag is set and its enable bit is high.

The carry state machine has these states:
- `ST_IDLE` waits for a second pulse. On a pulse it goes to `ST_SEC`.
- `ST_SEC` increments seconds. At 59 it wraps and goes to `ST_MIN`; otherwise it goes to `ST_IDLE`.
- `ST_MIN` increments minutes. At 59 it goes to `ST_HOUR`; otherwise to `ST_MATCH`.
- `ST_HOUR` increments hours. At 23 it goes to `ST_DAY`; otherwise to `ST_MATCH`.
- `ST_DAY` advances the weekday and the date. At the month's last day it goes to `ST_MONTH`; otherwise to `ST_MATCH`.
- `ST_MONTH` increments the month. At 12 it goes to `ST_YEAR`; otherwise to `ST_MATCH`.
- `ST_YEAR` increments the year and goes to `ST_MATCH`.
- `ST_MATCH` performs the alarm compare and returns to `ST_IDLE`.

A write to any time register (0x01 to 0x07) while the machine is outside `ST_IDLE` returns it to `ST_IDLE` that cycle. The write takes effect and the carry is dropped.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset the time registers read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, date 0x01, month 0x01 and year 0x00. The status register reads 0x03, meaning the low-voltage flag (bit 0) and the power-on flag (bit 1) are set. `irq_n` is high.
- R2: Seconds advance once per `TICKS_PER_SEC` pulses of `tick_in`. A write to the seconds register restarts the prescaler, so the next advance needs a full `TICKS_PER_SEC` pulses.
- R3: Seconds and minutes count in BCD from 00 to 59 and hours from 00 to 23. Each wraps to 00 and carries into the next field.
- R4: On a day carry the date returns to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. In February it returns after day 29 when the year is a multiple of four and after day 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00. The weekday (0 to 6) advances with each day, and 6 wraps to 0.
- R5: The register map is as follows. Writes keep only the listed bits; every other address reads 0x00.

  | Address | Register | Bits kept | Format |
  |---|---|---|---|
  | 0x01 | seconds | 7 | BCD |
  | 0x02 | minutes | 7 | BCD |
  | 0x03 | hours | 6 | BCD |
  | 0x04 | weekday | 3 | binary |
  | 0x05 | date | 6 | BCD |
  | 0x06 | month | 5 | BCD |
  | 0x07 | year | 8 | BCD |
  | 0x08 | alarm minute | 7 | BCD |
  | 0x09 | alarm hour | 6 | BCD |
  | 0x0A | alarm date | 6 | BCD |
  | 0x0D | status | see R8 | flags |
  | 0x11 | interrupt enables | 3 to 5 | bits |

- R6: The alarm flag (status bit 3) sets only on a second at which the seconds roll to 00 and the new minute, hour and date all equal the alarm registers.
- R7: The periodic-update flag (status bit 5) sets on every minute rollover and at no other time.
- R8: Writing the status register clears each flag bit written as 0 and leaves each bit written as 1 unchanged. The power-on flag stays set until it is cleared this way. A pulse on `volt_low` sets the low-voltage flag (bit 0).
- R9: A pulse on `timer_evt` sets the timer flag (status bit 4).
- R10: `irq_n` is low exactly while some flag at status bit 3, 4 or 5 is set together with the enable bit at the same position of register 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Prescaler enable pulse |
| timer_evt | input | 1 | Timer event stub, sets the timer flag |
| volt_low | input | 1 | Low-voltage indication, sets the low-voltage flag |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest cases to reach from the ports are the end-of-month and end-of-year carries, such as February in leap and non-leap years and the 99-to-00 year wrap. Counting there from reset would take millions of seconds. The bench instead writes a time of 23:59:59 with the chosen date, month and year directly into the registers. It then delivers exactly one second of prescaler pulses and reads back the new date, month, year and weekday. The alarm cases use the same preload. A negative case matches the alarm values without a seconds rollover and confirms that the alarm flag does not set.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam logic [7:0] A_SEC   = 8'h01;
    localparam logic [7:0] A_MIN   = 8'h02;
    localparam logic [7:0] A_HOUR  = 8'h03;
    localparam logic [7:0] A_WDAY  = 8'h04;
    localparam logic [7:0] A_DATE  = 8'h05;
    localparam logic [7:0] A_MON   = 8'h06;
    localparam logic [7:0] A_YEAR  = 8'h07;
    localparam logic [7:0] A_AMIN  = 8'h08;
    localparam logic [7:0] A_AHOUR = 8'h09;
    localparam logic [7:0] A_ADATE = 8'h0A;
    localparam logic [7:0] A_STAT  = 8'h0D;
    localparam logic [7:0] A_IEN   = 8'h11;

    // flag positions; enable bits share the positions of the event flags
    localparam int F_LOWV = 0;
    localparam int F_POR  = 1;
    localparam int F_ALM  = 3;
    localparam int F_TMR  = 4;
    localparam int F_UPD  = 5;

    localparam logic [7:0] FLAG_MASK = 8'b0011_1011;
    localparam logic [7:0] IEN_MASK  = 8'b0011_1000;
    localparam logic [7:0] FLAG_INIT = 8'b0000_0011;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DAY, ST_MONTH, ST_YEAR, ST_MATCH
    } cal_state_e;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic restart,
    output logic sec_pulse
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (restart)          cnt_q <= '0;
        else if (tick_in)          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign sec_pulse = tick_in && !restart && (cnt_q == LAST);
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [4:0] month,
    input  logic [4:0] year_low,   // bit 4: tens digit LSB, bits 3:0: ones digit
    output logic [5:0] last_day
);
    logic leap;

    always_comb begin
        if (year_low[4]) leap = (year_low[3:0] == 4'd2) || (year_low[3:0] == 4'd6);
        else             leap = (year_low[3:0] == 4'd0) || (year_low[3:0] == 4'd4) ||
                                (year_low[3:0] == 4'd8);
        case (month)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end
endmodule

// File: rtl/cal_status.sv
module cal_status
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_stat,
    input  logic       we_ien,
    input  logic [7:0] wdata,
    input  logic       set_alarm,
    input  logic       set_update,
    input  logic       set_timer,
    input  logic       set_lowv,
    output logic [7:0] flags_q,
    output logic [7:0] ien_q,
    output logic       irq_n
);
    logic [7:0] set_vec;
    logic [7:0] clr_vec;

    always_comb begin
        set_vec         = '0;
        set_vec[F_ALM]  = set_alarm;
        set_vec[F_UPD]  = set_update;
        set_vec[F_TMR]  = set_timer;
        set_vec[F_LOWV] = set_lowv;
        clr_vec         = we_stat ? (~wdata & FLAG_MASK) : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= FLAG_INIT;
            ien_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (we_ien) ien_q <= wdata & IEN_MASK;
        end
    end

    assign irq_n = ~|(flags_q & ien_q & IEN_MASK);
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       timer_evt,
    input  logic       volt_low,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    output logic [7:0] bus_rdata,
    output logic       irq_n
);
    cal_state_e state_q, state_d;

    logic [6:0] sec_q, min_q, amin_q;
    logic [5:0] hour_q, date_q, ahour_q, adate_q;
    logic [2:0] wday_q;
    logic [4:0] mon_q;
    logic [7:0] year_q;
    logic [7:0] stat_q, ien_q;
    logic [5:0] last_day;
    logic       sec_pulse, time_wr, set_alarm, set_update;
    logic [7:0] sec_inc, min_inc, hour_inc, date_inc, mon_inc, year_inc;

    assign time_wr  = bus_we && (bus_addr >= A_SEC) && (bus_addr <= A_YEAR);
    assign sec_inc  = bcd_inc({1'b0, sec_q});
    assign min_inc  = bcd_inc({1'b0, min_q});
    assign hour_inc = bcd_inc({2'b0, hour_q});
    assign date_inc = bcd_inc({2'b0, date_q});
    assign mon_inc  = bcd_inc({3'b0, mon_q});
    assign year_inc = bcd_inc(year_q);

    cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .restart(bus_we && bus_addr == A_SEC), .sec_pulse(sec_pulse)
    );

    cal_month_len u_mlen (
        .month(mon_q), .year_low(year_q[4:0]), .last_day(last_day)
    );

    cal_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .we_stat(bus_we && bus_addr == A_STAT), .we_ien(bus_we && bus_addr == A_IEN),
        .wdata(bus_wdata), .set_alarm(set_alarm), .set_update(set_update),
        .set_timer(timer_evt), .set_lowv(volt_low),
        .flags_q(stat_q), .ien_q(ien_q), .irq_n(irq_n)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = sec_pulse ? ST_SEC : ST_IDLE;
            ST_SEC:   state_d = (sec_q == 7'h59) ? ST_MIN : ST_IDLE;
            ST_MIN:   state_d = (min_q == 7'h59) ? ST_HOUR : ST_MATCH;
            ST_HOUR:  state_d = (hour_q == 6'h23) ? ST_DAY : ST_MATCH;
            ST_DAY:   state_d = (date_q == last_day) ? ST_MONTH : ST_MATCH;
            ST_MONTH: state_d = (mon_q == 5'h12) ? ST_YEAR : ST_MATCH;
            ST_YEAR:  state_d = ST_MATCH;
            ST_MATCH: state_d = ST_IDLE;
        endcase
        if (time_wr && state_q != ST_IDLE) state_d = ST_IDLE;
    end

    // outputs of the state machine
    always_comb begin
        set_update = (state_q == ST_SEC) && (sec_q == 7'h59) && !time_wr;
        set_alarm  = (state_q == ST_MATCH) && (min_q == amin_q) &&
                     (hour_q == ahour_q) && (date_q == adate_q);
    end

    // time and date counters: a bus write wins over the carry step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= '0;     min_q  <= '0;     hour_q <= '0;   wday_q <= '0;
            date_q <= 6'h01;  mon_q  <= 5'h01;  year_q <= '0;
        end else if (time_wr) begin
            case (bus_addr)
                A_SEC:   sec_q  <= bus_wdata[6:0];
                A_MIN:   min_q  <= bus_wdata[6:0];
                A_HOUR:  hour_q <= bus_wdata[5:0];
                A_WDAY:  wday_q <= bus_wdata[2:0];
                A_DATE:  date_q <= bus_wdata[5:0];
                A_MON:   mon_q  <= bus_wdata[4:0];
                default: year_q <= bus_wdata;
            endcase
        end else begin
            case (state_q)
                ST_SEC:   sec_q  <= (sec_q == 7'h59) ? 7'h00 : sec_inc[6:0];
                ST_MIN:   min_q  <= (min_q == 7'h59) ? 7'h00 : min_inc[6:0];
                ST_HOUR:  hour_q <= (hour_q == 6'h23) ? 6'h00 : hour_inc[5:0];
                ST_DAY: begin
                    wday_q <= (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
                    date_q <= (date_q == last_day) ? 6'h01 : date_inc[5:0];
                end
                ST_MONTH: mon_q  <= (mon_q == 5'h12) ? 5'h01 : mon_inc[4:0];
                ST_YEAR:  year_q <= (year_q == 8'h99) ? 8'h00 : year_inc;
                default: ;
            endcase
        end
    end

    // alarm registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amin_q <= '0; ahour_q <= '0; adate_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_AMIN)  amin_q  <= bus_wdata[6:0];
            if (bus_addr == A_AHOUR) ahour_q <= bus_wdata[5:0];
            if (bus_addr == A_ADATE) adate_q <= bus_wdata[5:0];
        end
    end

    // read port
    always_comb begin
        case (bus_addr)
            A_SEC:   bus_rdata = {1'b0, sec_q};
            A_MIN:   bus_rdata = {1'b0, min_q};
            A_HOUR:  bus_rdata = {2'b0, hour_q};
            A_WDAY:  bus_rdata = {5'b0, wday_q};
            A_DATE:  bus_rdata = {2'b0, date_q};
            A_MON:   bus_rdata = {3'b0, mon_q};
            A_YEAR:  bus_rdata = year_q;
            A_AMIN:  bus_rdata = {1'b0, amin_q};
            A_AHOUR: bus_rdata = {2'b0, ahour_q};
            A_ADATE: bus_rdata = {2'b0, adate_q};
            A_STAT:  bus_rdata = stat_q;
            A_IEN:   bus_rdata = ien_q;
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cal_timekeeper_chk.sv
module cal_timekeeper_chk
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input cal_state_e state_q,
    input logic       sec_pulse,
    input logic [6:0] sec_q,
    input logic       bus_we,
    input logic [7:0] bus_addr,
    input logic       wdata_por,
    input logic [2:0] evt_flags,
    input logic       por_flag,
    input logic       irq_n
);
    // R2
    sec_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEC) |-> $past(sec_pulse));

    // R3
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEC && !(bus_we && bus_addr >= A_SEC && bus_addr <= A_YEAR))
        |=> (sec_q != $past(sec_q)));

    // R6
    alarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flags[0]) |-> $past(state_q == ST_MATCH));

    // R7
    update_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flags[2]) |-> $past(state_q == ST_SEC));

    // R8
    por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_flag) |-> $past(bus_we && bus_addr == A_STAT && !wdata_por));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flags == 3'b000) |-> irq_n);
endmodule

bind cal_timekeeper cal_timekeeper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .sec_pulse(sec_pulse),
    .sec_q(sec_q), .bus_we(bus_we), .bus_addr(bus_addr),
    .wdata_por(bus_wdata[1]), .evt_flags(stat_q[5:3]), .por_flag(stat_q[1]),
    .irq_n(irq_n)
);

// File: tb/tb_cal_timekeeper.sv
`timescale 1ns/1ps
module tb_cal_timekeeper;
    localparam int TPS = 4;
    localparam int NVEC = 13;
    // {address, write data, expected read-back}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h01_FF_7F, 24'h02_A5_25, 24'h03_FF_3F, 24'h04_FF_07,
        24'h05_C9_09, 24'h06_FF_1F, 24'h07_99_99, 24'h08_D7_57,
        24'h09_E3_23, 24'h0A_31_31, 24'h11_FF_38, 24'h20_FF_00,
        24'h0C_55_00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0, timer_evt = 1'b0, volt_low = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_n;
    int         checks = 0, errors = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    cal_timekeeper #(.TICKS_PER_SEC(TPS)) dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .timer_evt(timer_evt),
        .volt_low(volt_low), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk); bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input logic [7:0] wd, input logic [7:0] d,
                            input logic [7:0] mo, input logic [7:0] y);
        wr(8'h01, s); wr(8'h02, m); wr(8'h03, h); wr(8'h04, wd);
        wr(8'h05, d); wr(8'h06, mo); wr(8'h07, y);
    endtask

    // R4: preload 23:59:59 on a date, advance one second, check the new date
    task automatic day_roll(input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y, input logic [7:0] ewd, input logic [7:0] ed,
                            input logic [7:0] emo, input logic [7:0] ey);
        set_time(8'h23, 8'h59, 8'h59, wd, d, mo, y);
        pulse_ticks(TPS);
        rd_chk("R4 date", 8'h05, ed);
        rd_chk("R4 month", 8'h06, emo);
        rd_chk("R4 year", 8'h07, ey);
        rd_chk("R4 weekday", 8'h04, ewd);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 sec", 8'h01, 8'h00);
        rd_chk("R1 min", 8'h02, 8'h00);
        rd_chk("R1 hour", 8'h03, 8'h00);
        rd_chk("R1 wday", 8'h04, 8'h00);
        rd_chk("R1 date", 8'h05, 8'h01);
        rd_chk("R1 month", 8'h06, 8'h01);
        rd_chk("R1 year", 8'h07, 8'h00);
        rd_chk("R1 status", 8'h0D, 8'h03);
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);

        // R5 register map walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd_chk("R5 readback", VEC[i][23:16], VEC[i][7:0]);
        end
        wr(8'h11, 8'h00);

        // R8 write-zero-to-clear, power-on flag held until cleared
        wr(8'h0D, 8'hFD);
        rd_chk("R8 clear por only", 8'h0D, 8'h01);
        wr(8'h0D, 8'h00);
        rd_chk("R8 clear all", 8'h0D, 8'h00);

        // R2 prescaler and restart on seconds write
        wr(8'h01, 8'h10);
        pulse_ticks(TPS - 1);
        rd_chk("R2 no advance yet", 8'h01, 8'h10);
        pulse_ticks(1);
        rd_chk("R2 advance", 8'h01, 8'h11);
        pulse_ticks(2);
        wr(8'h01, 8'h20);
        pulse_ticks(TPS - 1);
        rd_chk("R2 restart holds", 8'h01, 8'h20);
        pulse_ticks(1);
        rd_chk("R2 restart advance", 8'h01, 8'h21);

        // R3 / R7 rollover of seconds, minutes, hours
        wr(8'h08, 8'h45);
        set_time(8'h23, 8'h59, 8'h58, 8'h02, 8'h15, 8'h03, 8'h21);
        wr(8'h0D, 8'h00);
        pulse_ticks(TPS);
        rd_chk("R3 sec 59", 8'h01, 8'h59);
        rd_chk("R7 no update before rollover", 8'h0D, 8'h00);
        pulse_ticks(TPS);
        rd_chk("R3 sec wrap", 8'h01, 8'h00);
        rd_chk("R3 min wrap", 8'h02, 8'h00);
        rd_chk("R3 hour wrap", 8'h03, 8'h00);
        rd_chk("R3 date carry", 8'h05, 8'h16);
        rd_chk("R7 update flag", 8'h0D, 8'h20);

        // R10 interrupt gating
        check("R10 masked", {7'b0, irq_n}, 8'h01);
        wr(8'h11, 8'h20);
        check("R10 enabled", {7'b0, irq_n}, 8'h00);
        wr(8'h11, 8'h18);
        check("R10 other enables", {7'b0, irq_n}, 8'h01);
        wr(8'h11, 8'h00);

        // R3 minute carry without hour carry
        set_time(8'h09, 8'h39, 8'h59, 8'h01, 8'h02, 8'h02, 8'h22);
        pulse_ticks(TPS);
        rd_chk("R3 min inc", 8'h02, 8'h40);
        rd_chk("R3 hour hold", 8'h03, 8'h09);

        // R4 month lengths, leap years, year wrap, weekday wrap
        day_roll(8'h03, 8'h30, 8'h04, 8'h21, 8'h04, 8'h01, 8'h05, 8'h21);
        day_roll(8'h06, 8'h28, 8'h02, 8'h21, 8'h00, 8'h01, 8'h03, 8'h21);
        day_roll(8'h00, 8'h28, 8'h02, 8'h24, 8'h01, 8'h29, 8'h02, 8'h24);
        day_roll(8'h01, 8'h29, 8'h02, 8'h24, 8'h02, 8'h01, 8'h03, 8'h24);
        day_roll(8'h02, 8'h28, 8'h02, 8'h00, 8'h03, 8'h29, 8'h02, 8'h00);
        day_roll(8'h04, 8'h30, 8'h01, 8'h05, 8'h05, 8'h31, 8'h01, 8'h05);
        day_roll(8'h05, 8'h31, 8'h12, 8'h99, 8'h06, 8'h01, 8'h01, 8'h00);

        // R6 alarm match at seconds rollover
        wr(8'h08, 8'h10); wr(8'h09, 8'h08); wr(8'h0A, 8'h05);
        set_time(8'h08, 8'h09, 8'h59, 8'h01, 8'h05, 8'h06, 8'h23);
        wr(8'h0D, 8'h00);
        pulse_ticks(TPS);
        rd_chk("R6 alarm fires", 8'h0D, 8'h28);
        wr(8'h11, 8'h08);
        check("R10 alarm irq", {7'b0, irq_n}, 8'h00);
        wr(8'h11, 8'h00);
        // R6 date mismatch: no alarm
        set_time(8'h08, 8'h09, 8'h59, 8'h01, 8'h06, 8'h06, 8'h23);
        wr(8'h0D, 8'h00);
        pulse_ticks(TPS);
        rd_chk("R6 date mismatch", 8'h0D, 8'h20);
        // R6 match without rollover: no alarm
        set_time(8'h08, 8'h10, 8'h30, 8'h01, 8'h05, 8'h06, 8'h23);
        wr(8'h0D, 8'h00);
        pulse_ticks(TPS);
        rd_chk("R6 no rollover", 8'h0D, 8'h00);

        // R9 timer stub, R8 low voltage and write-one-keeps
        @(negedge clk); timer_evt = 1'b1;
        @(negedge clk); timer_evt = 1'b0;
        rd_chk("R9 timer flag", 8'h0D, 8'h10);
        wr(8'h11, 8'h10);
        check("R10 timer irq", {7'b0, irq_n}, 8'h00);
        @(negedge clk); volt_low = 1'b1;
        @(negedge clk); volt_low = 1'b0;
        rd_chk("R8 low voltage flag", 8'h0D, 8'h11);
        wr(8'h0D, 8'hEF);
        rd_chk("R8 ones keep", 8'h0D, 8'h01);
        check("R10 irq released", {7'b0, irq_n}, 8'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule